// File: doc/BRIEF.md
# System Controller Register Bank

This block collects the small control and status registers of a chip behind one word-addressed, 32-bit register port. It holds a GPIO output word and a GPIO interrupt-enable word, which drive output ports. It also holds two identical timer register sets, an 8-bit debug scratchpad and a sticky debug lock. Four read-only words report the GPIO strapping value, the system clock frequency, a capability word and a system identifier. A command register reads as "ready". Two kinds of write do more than store data. A write to the identifier word raises a one-cycle reset request. A write of the shutdown code to the command register raises a one-cycle shutdown request.

A bus master issues one request per cycle with a byte address, a byte-enable mask and write data. Only aligned accesses with all four byte enables set take effect. Reads answer one cycle later on a registered response port. The fixed identity values are parameters, so each chip can set its own.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset these words read as follows. Command register (word 16) reads 1. System ID (word 31) reads 0x10014D31. Clock frequency (word 29) reads 80000000 (0x04C4B400). Capabilities (word 30) read 0. GPIO input (word 0) reads the strapping value 0x1. Every writable register reads 0, and reset_req, shutdown_req, gpio_out and gpio_irq_en are 0.
- R2: The word index is the byte address shifted right by 2. Word 1 is GPIO output and word 2 is GPIO interrupt enable. Timer 0 uses words 4, 5 and 6 for control, compare and counter. Timer 1 uses words 8, 9 and 10. Scratchpad is word 20 and lock is word 21. The two timers are independent.
- R3: A read request gives rsp_valid high for exactly one cycle, in the cycle after the request edge, with the data on rsp_rdata.
- R4: GPIO output, GPIO interrupt enable, and each timer's compare and counter words store all 32 bits. gpio_out and gpio_irq_en show the stored words. A timer control word stores bits [1:0] and reads 0 in the bits above.
- R5: The scratchpad stores write-data bits [7:0] and reads zero in bits [31:8].
- R6: Any write to the lock word makes it read 1, whatever data is written, and it stays 1 until reset.
- R7: Any write to the system-ID word drives reset_req high for one cycle, in the cycle after the write edge. The ID value does not change.
- R8: A write to the command word whose bits [15:0] equal 0x000E drives shutdown_req high for one cycle, in the cycle after the write edge. Other values give no pulse. The command word keeps reading 1.
- R9: Writes to the GPIO input, clock frequency and capability words are ignored.
- R10: Reads of unmapped words (3, 7, 11–15, 17–19, 22–28) return 0, and writes to them change nothing.
- R11: An access with req_be not equal to 4'hF, or with req_addr[1:0] not 0, has no effect and causes no pulse. A rejected read still responds, with data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte address |
| req_be | input | 4 | Byte enables; only 4'hF is accepted |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| gpio_out | output | 32 | GPIO output word |
| gpio_irq_en | output | 32 | GPIO interrupt-enable word |
| reset_req | output | 1 | One-cycle system reset request |
| shutdown_req | output | 1 | One-cycle shutdown request |

## Verification
A read answers in the cycle after its request edge. The bench drives each request on a falling edge, records the expected word in a scoreboard queue, and a monitor compares rsp_rdata on the next falling edge, where rsp_valid must be high. Register writes are due at the write edge, so the bench checks them with a later read, and checks gpio_out and gpio_irq_en at the falling edge after that write edge. Reset and shutdown pulses are checked high at the falling edge that follows the write edge, and low one cycle later. Cases that must not pulse are checked at the same two points.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int WORD_W  = 32;
    localparam int IDX_W   = 5;
    localparam int ADDR_W  = IDX_W + 2;
    localparam int BE_W    = WORD_W / 8;

    localparam logic [IDX_W-1:0] IDX_GPIO_IN  = 5'd0;
    localparam logic [IDX_W-1:0] IDX_GPIO_OUT = 5'd1;
    localparam logic [IDX_W-1:0] IDX_IRQ_EN   = 5'd2;
    localparam logic [IDX_W-1:0] IDX_CMD      = 5'd16;
    localparam logic [IDX_W-1:0] IDX_SCRATCH  = 5'd20;
    localparam logic [IDX_W-1:0] IDX_LOCK     = 5'd21;
    localparam logic [IDX_W-1:0] IDX_FREQ     = 5'd29;
    localparam logic [IDX_W-1:0] IDX_CAPS     = 5'd30;
    localparam logic [IDX_W-1:0] IDX_ID       = 5'd31;

    localparam int NUM_TMR    = 2;
    localparam int TMR_BASE   = 4;
    localparam int TMR_STRIDE = 4;

    localparam logic [15:0] CMD_SHUTDOWN = 16'h000E;

    typedef enum logic [1:0] {
        TR_CTRL = 2'd0,
        TR_CMP  = 2'd1,
        TR_CNT  = 2'd2
    } tmr_reg_e;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    output logic              rd_req,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic [IDX_W-1:0]  widx,
    output logic [NUM_TMR-1:0] tmr_hit,
    output logic [1:0]        tmr_sel
);

    logic acc_ok;

    always_comb begin
        acc_ok = req_valid && (req_be == {BE_W{1'b1}}) && (req_addr[1:0] == 2'b00);
        rd_req = req_valid && !req_write;
        rd_ok  = acc_ok && !req_write;
        wr_ok  = acc_ok && req_write;
        widx   = req_addr[ADDR_W-1:2];
        tmr_sel = widx[1:0];
    end

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_hit
        localparam int BLK = (TMR_BASE + TMR_STRIDE * t) / 4;
        always_comb begin
            tmr_hit[t] = (int'(widx[IDX_W-1:2]) == BLK) && (widx[1:0] != 2'd3);
        end
    end

endmodule

// File: rtl/sysctl_timer_regs.sv
module sysctl_timer_regs
    import sysctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CTRL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] cmp;
        logic [DATA_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (sel)
                TR_CTRL: s_d.ctrl = wdata[CTRL_W-1:0];
                TR_CMP:  s_d.cmp  = wdata;
                TR_CNT:  s_d.cnt  = wdata;
                default: ;
            endcase
        end
        case (sel)
            TR_CTRL: rdata = {{(DATA_W-CTRL_W){1'b0}}, s_q.ctrl};
            TR_CMP:  rdata = s_q.cmp;
            TR_CNT:  rdata = s_q.cnt;
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: a timer's words hold their value when this instance is not written
    assert_tmr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(s_q));

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter logic [WORD_W-1:0] SYS_ID    = 32'h10014D31,
    parameter logic [WORD_W-1:0] CLK_HZ    = 32'd80000000,
    parameter logic [WORD_W-1:0] CAPS      = 32'h0,
    parameter logic [WORD_W-1:0] STRAP     = 32'h1,
    parameter int                SCRATCH_W = 8,
    parameter int                TCTRL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [6:0]        req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic [31:0]       gpio_out,
    output logic [31:0]       gpio_irq_en,
    output logic              reset_req,
    output logic              shutdown_req
);

    localparam logic [WORD_W-1:0] CMD_READY = 32'h1;

    typedef struct packed {
        logic [WORD_W-1:0]    gpio_out;
        logic [WORD_W-1:0]    irq_en;
        logic [SCRATCH_W-1:0] scratch;
        logic                 lock;
        logic                 rsp_valid;
        logic [WORD_W-1:0]    rdata;
        logic                 rst_req;
        logic                 shut_req;
    } st_t;

    st_t s_d, s_q;

    logic               rd_req, rd_ok, wr_ok;
    logic [IDX_W-1:0]   widx;
    logic [NUM_TMR-1:0] tmr_hit;
    logic [1:0]         tmr_sel;
    logic [WORD_W-1:0]  tmr_rdata [NUM_TMR];

    sysctl_decode u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .rd_req    (rd_req),
        .rd_ok     (rd_ok),
        .wr_ok     (wr_ok),
        .widx      (widx),
        .tmr_hit   (tmr_hit),
        .tmr_sel   (tmr_sel)
    );

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        sysctl_timer_regs #(
            .DATA_W (WORD_W),
            .CTRL_W (TCTRL_W)
        ) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_ok && tmr_hit[t]),
            .sel   (tmr_sel),
            .wdata (req_wdata),
            .rdata (tmr_rdata[t])
        );
    end

    always_comb begin
        logic [WORD_W-1:0] mux;
        s_d          = s_q;
        s_d.rst_req  = 1'b0;
        s_d.shut_req = 1'b0;

        if (wr_ok) begin
            case (widx)
                IDX_GPIO_OUT: s_d.gpio_out = req_wdata;
                IDX_IRQ_EN:   s_d.irq_en   = req_wdata;
                IDX_SCRATCH:  s_d.scratch  = req_wdata[SCRATCH_W-1:0];
                IDX_LOCK:     s_d.lock     = 1'b1;
                IDX_ID:       s_d.rst_req  = 1'b1;
                IDX_CMD:      s_d.shut_req = (req_wdata[15:0] == CMD_SHUTDOWN);
                default: ;
            endcase
        end

        mux = '0;
        case (widx)
            IDX_GPIO_IN:  mux = STRAP;
            IDX_GPIO_OUT: mux = s_q.gpio_out;
            IDX_IRQ_EN:   mux = s_q.irq_en;
            IDX_CMD:      mux = CMD_READY;
            IDX_SCRATCH:  mux = {{(WORD_W-SCRATCH_W){1'b0}}, s_q.scratch};
            IDX_LOCK:     mux = {{(WORD_W-1){1'b0}}, s_q.lock};
            IDX_FREQ:     mux = CLK_HZ;
            IDX_CAPS:     mux = CAPS;
            IDX_ID:       mux = SYS_ID;
            default: ;
        endcase
        for (int t = 0; t < NUM_TMR; t++) begin
            if (tmr_hit[t]) mux = tmr_rdata[t];
        end

        s_d.rsp_valid = rd_req;
        s_d.rdata     = rd_ok ? mux : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid    = s_q.rsp_valid;
    assign rsp_rdata    = s_q.rdata;
    assign gpio_out     = s_q.gpio_out;
    assign gpio_irq_en  = s_q.irq_en;
    assign reset_req    = s_q.rst_req;
    assign shutdown_req = s_q.shut_req;

    // R3: response follows a read request by one cycle and lasts one cycle
    assert_rsp_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    // R6: lock never clears once set
    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lock |=> s_q.lock);

    // R7: reset request is a single-cycle pulse caused by a full ID write
    assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);
    assert_rst_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(req_valid && req_write && req_be == 4'hF &&
                            req_addr == {IDX_ID, 2'b00}));

    // R8: shutdown request is a single-cycle pulse caused by a command write
    assert_shut_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> !shutdown_req);
    assert_shut_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(req_valid && req_write && req_be == 4'hF &&
                               req_addr == {IDX_CMD, 2'b00} &&
                               req_wdata[15:0] == 16'h000E));

endmodule

// File: tb/sysctl_regbank_tb.sv
module sysctl_regbank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [31:0] gpio_out;
    logic [31:0] gpio_irq_en;
    logic        reset_req;
    logic        shutdown_req;

    int n_checks = 0;
    int n_errors = 0;

    logic [31:0] exp_q [$];
    int          tag_q [$];

    always #5 clk = ~clk;

    sysctl_regbank u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_be       (req_be),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .gpio_out     (gpio_out),
        .gpio_irq_en  (gpio_irq_en),
        .reset_req    (reset_req),
        .shutdown_req (shutdown_req)
    );

    task automatic check(input bit ok, input int req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL R%0d: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, 3, rsp_rdata, 32'hDEADDEAD);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic int          g = tag_q.pop_front();
                check(rsp_rdata === e, g, rsp_rdata, e);
            end
        end
    end

    task automatic access(input bit wr, input logic [6:0] a, input logic [3:0] be,
                          input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        access(1'b1, 7'(idx * 4), 4'hF, d);
    endtask

    task automatic rd(input int idx, input logic [31:0] e, input int tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        access(1'b0, 7'(idx * 4), 4'hF, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, 0, 32'h0, 32'h1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports and in the registers
        check(reset_req == 1'b0 && shutdown_req == 1'b0, 1, {30'h0, reset_req, shutdown_req}, 32'h0);
        check(gpio_out == 32'h0, 1, gpio_out, 32'h0);
        check(gpio_irq_en == 32'h0, 1, gpio_irq_en, 32'h0);
        rd(0, 32'h1, 1);
        rd(16, 32'h1, 1);
        rd(31, 32'h10014D31, 1);
        rd(29, 32'h04C4B400, 1);
        rd(30, 32'h0, 1);
        rd(20, 32'h0, 1);
        rd(21, 32'h0, 1);
        for (int i = 4; i <= 10; i++) if (i != 7) rd(i, 32'h0, 1);

        // R4: full-width storage and outputs
        wr(1, 32'hA5A5_3C3C);
        check(gpio_out == 32'hA5A5_3C3C, 4, gpio_out, 32'hA5A5_3C3C);
        wr(2, 32'h0F0F_8001);
        check(gpio_irq_en == 32'h0F0F_8001, 4, gpio_irq_en, 32'h0F0F_8001);
        rd(1, 32'hA5A5_3C3C, 4);
        rd(2, 32'h0F0F_8001, 4);

        // R2 / R4: timer words, independent instances, control width
        wr(4, 32'hFFFF_FFFF);
        wr(5, 32'h1111_2222);
        wr(6, 32'h3333_4444);
        wr(8, 32'h0000_0002);
        wr(9, 32'h5555_6666);
        wr(10, 32'h7777_8888);
        rd(4, 32'h3, 4);
        rd(5, 32'h1111_2222, 2);
        rd(6, 32'h3333_4444, 2);
        rd(8, 32'h2, 2);
        rd(9, 32'h5555_6666, 2);
        rd(10, 32'h7777_8888, 2);

        // R5: scratchpad width
        wr(20, 32'h1234_56AB);
        rd(20, 32'h0000_00AB, 5);

        // R6: lock set by any data, stays set
        wr(21, 32'h0);
        rd(21, 32'h1, 6);
        wr(21, 32'h0);
        rd(21, 32'h1, 6);

        // R7: ID write pulses reset request
        wr(31, 32'h0);
        check(reset_req == 1'b1, 7, {31'h0, reset_req}, 32'h1);
        @(negedge clk);
        check(reset_req == 1'b0, 7, {31'h0, reset_req}, 32'h0);
        rd(31, 32'h10014D31, 7);

        // R8: shutdown code, and a non-matching code
        wr(16, 32'hFFFF_000E);
        check(shutdown_req == 1'b1, 8, {31'h0, shutdown_req}, 32'h1);
        @(negedge clk);
        check(shutdown_req == 1'b0, 8, {31'h0, shutdown_req}, 32'h0);
        wr(16, 32'h0000_000F);
        check(shutdown_req == 1'b0, 8, {31'h0, shutdown_req}, 32'h0);
        rd(16, 32'h1, 8);

        // R9: read-only words ignore writes
        wr(0, 32'hFFFF_FFFF);
        wr(29, 32'h0);
        wr(30, 32'hFFFF_FFFF);
        rd(0, 32'h1, 9);
        rd(29, 32'h04C4B400, 9);
        rd(30, 32'h0, 9);

        // R10: unmapped words
        wr(3, 32'hCAFE_F00D);
        wr(7, 32'hCAFE_F00D);
        rd(3, 32'h0, 10);
        rd(7, 32'h0, 10);
        rd(11, 32'h0, 10);
        rd(17, 32'h0, 10);
        rd(25, 32'h0, 10);
        check(gpio_out == 32'hA5A5_3C3C, 10, gpio_out, 32'hA5A5_3C3C);

        // R11: partial and misaligned accesses
        access(1'b1, 7'd4, 4'h3, 32'h0);
        check(gpio_out == 32'hA5A5_3C3C, 11, gpio_out, 32'hA5A5_3C3C);
        access(1'b1, 7'd125, 4'hF, 32'h0);
        check(reset_req == 1'b0, 11, {31'h0, reset_req}, 32'h0);
        access(1'b1, 7'd64, 4'h7, 32'h0000_000E);
        check(shutdown_req == 1'b0, 11, {31'h0, shutdown_req}, 32'h0);
        exp_q.push_back(32'h0); tag_q.push_back(11);
        access(1'b0, 7'd124, 4'h1, 32'h0);
        exp_q.push_back(32'h0); tag_q.push_back(11);
        access(1'b0, 7'd6, 4'hF, 32'h0);

        repeat (3) @(negedge clk);
        // R3: every expected response arrived
        check(exp_q.size() == 0, 3, 32'(exp_q.size()), 32'h0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule